// File: doc/BRIEF.md
# Two-Tone FSK Step-Learning Controller

This block sits between the digital loop filter of a low-bandwidth fractional-N synthesizer and a pair of oscillator-tuning DACs, one DAC per FSK tone. It holds one unsigned control word per tone. While a tone is transmitted, signed corrections from the loop are added to that tone's word only. The other tone's word stays frozen. An external analog multiplexer picks the DAC that drives the oscillator, and its select line follows the transmitted bit. The frequency therefore moves as soon as the bit changes, however slow the loop is.

When an accepted data bit differs from the current tone, the block does two things on the same edge. It loads the incoming tone's word with the outgoing tone's word, offset by the step it learned at the previous switch. It also samples both words and records their difference as the new step. The step is learned from the words themselves, so no oscillator gain is needed, and it is updated only at data transitions. Over repeated toggles the loaded value converges onto the word that the loop itself settles at. A drift in oscillator gain is absorbed by the step updates that follow.

Top module: `fsk_step_mod`

## Requirements
- R1: While `rst` is high, at the next rising edge both `dac_lo` and `dac_hi` become `RESET_WORD` (default 128), `tone_sel` becomes 0 and the learned step becomes zero.
- R2: A data bit is accepted only in a cycle with `sym_stb` high. `tone_sel` takes the accepted bit one clock later (0 = low tone on `dac_lo`, 1 = high tone on `dac_hi`). `data_bit` has no effect without the strobe.
- R3: In a cycle with no switch and `corr_vld` high, the signed `corr` is added to the word of the tone that `tone_sel` selects, and the other word is unchanged. With `corr_vld` low and no switch, both words hold.
- R4: A switch is an accepted bit that differs from `tone_sel`. On a 0-to-1 switch, `dac_hi` is loaded with `dac_lo + step`. On a 1-to-0 switch, `dac_lo` is loaded with `dac_hi - step`. The outgoing tone's word is unchanged. `step` is the value learned at the previous switch.
- R5: At every switch the step becomes `dac_hi - dac_lo`, using the values just before the switch. The first switch after reset uses a step of zero. If the loop settles each tone to a fixed word, then from the third switch on the loaded word equals that settled word.
- R6: A strobe carrying the bit already selected is not a switch. It samples nothing, loads nothing and leaves the step unchanged.
- R7: Both words saturate to the DAC range 0 to 2^W-1, for corrections and for switch loads. The learned step always lies within ±(2^W-1).
- R8: In a cycle that switches, any correction presented that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_stb | input | 1 | Data-period strobe; `data_bit` is accepted when high |
| data_bit | input | 1 | Transmit data bit |
| corr_vld | input | 1 | Loop correction valid |
| corr | input | CW | Signed loop correction for the active tone |
| dac_lo | output | W | Control word for the low-tone DAC |
| dac_hi | output | W | Control word for the high-tone DAC |
| tone_sel | output | 1 | Select for the external analog multiplexer |

## Verification
Positive and negative corrections on one tone, with the other tone's word watched, show that the correction reaches only the path that is selected. Strobes that repeat the current bit, and bit changes without a strobe, are mixed with real switches; this tells sampling at data edges apart from sampling every cycle or every strobe. The bench imitates a loop that moves each tone toward a fixed target word. Across several toggles this exposes the zero step on the first switch, the step learned at the second switch and exact landing from the third switch on. A driven-to-the-rails sequence, with large negative steps, hits saturation at both ends. It covers both corrections and switch loads.

// File: rtl/fsk_step_pkg.sv
`timescale 1ns/1ps
package fsk_step_pkg;

    typedef enum logic {
        TONE_LO = 1'b0,
        TONE_HI = 1'b1
    } tone_e;

    // events decoded from one cycle of input
    typedef struct packed {
        logic  xfer;     // accepted bit differs from current tone
        tone_e dest;     // tone selected after this cycle
        logic  corr_ok;  // correction applies this cycle
    } sym_ev_t;

    function automatic int sat_int(input int v, input int top);
        if (v < 0)
            return 0;
        else if (v > top)
            return top;
        else
            return v;
    endfunction

endpackage

// File: rtl/fsk_sym_edge.sv
`timescale 1ns/1ps
module fsk_sym_edge
    import fsk_step_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sym_stb,
    input  logic    data_bit,
    input  logic    corr_vld,
    output tone_e   tone_q,
    output sym_ev_t ev
);

    always_comb begin
        ev.xfer    = sym_stb && (tone_e'(data_bit) != tone_q);
        ev.dest    = sym_stb ? tone_e'(data_bit) : tone_q;
        ev.corr_ok = corr_vld && !ev.xfer;
    end

    always_ff @(posedge clk) begin
        if (rst)
            tone_q <= TONE_LO;
        else
            tone_q <= ev.dest;
    end

endmodule

// File: rtl/fsk_step_learn.sv
`timescale 1ns/1ps
module fsk_step_learn #(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                xfer,
    input  logic [W-1:0]        word_lo,
    input  logic [W-1:0]        word_hi,
    output logic signed [W:0]   step_q
);

    logic signed [W:0] diff;

    // difference of two W-bit words always fits W+1 signed bits
    always_comb diff = $signed({1'b0, word_hi}) - $signed({1'b0, word_lo});

    always_ff @(posedge clk) begin
        if (rst)
            step_q <= '0;
        else if (xfer)
            step_q <= diff;
    end

endmodule

// File: rtl/fsk_tone_path.sv
`timescale 1ns/1ps
module fsk_tone_path #(
    parameter int W          = 8,
    parameter int CW         = 6,
    parameter int RESET_WORD = 128
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_en,
    input  logic [W-1:0]         load_val,
    input  logic                 add_en,
    input  logic signed [CW-1:0] corr,
    output logic [W-1:0]         word_q
);

    localparam int WMAX = (1 << W) - 1;

    logic [W-1:0] added;

    always_comb begin
        int sum;
        sum   = int'(word_q) + int'(corr);
        added = W'(fsk_step_pkg::sat_int(sum, WMAX));
    end

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= W'(RESET_WORD);
        else if (load_en)
            word_q <= load_val;
        else if (add_en)
            word_q <= added;
    end

endmodule

// File: rtl/fsk_step_mod.sv
`timescale 1ns/1ps
module fsk_step_mod
    import fsk_step_pkg::*;
#(
    parameter int W          = 8,
    parameter int CW         = 6,
    parameter int RESET_WORD = 128
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sym_stb,
    input  logic                 data_bit,
    input  logic                 corr_vld,
    input  logic signed [CW-1:0] corr,
    output logic [W-1:0]         dac_lo,
    output logic [W-1:0]         dac_hi,
    output logic                 tone_sel
);

    localparam int WMAX   = (1 << W) - 1;
    localparam int NTONES = 2;

    tone_e             tone_q;
    sym_ev_t           ev;
    logic signed [W:0] step_q;
    logic [W-1:0]      words [NTONES];

    fsk_sym_edge edge_i (
        .clk      (clk),
        .rst      (rst),
        .sym_stb  (sym_stb),
        .data_bit (data_bit),
        .corr_vld (corr_vld),
        .tone_q   (tone_q),
        .ev       (ev)
    );

    fsk_step_learn #(.W(W)) learn_i (
        .clk     (clk),
        .rst     (rst),
        .xfer    (ev.xfer),
        .word_lo (words[0]),
        .word_hi (words[1]),
        .step_q  (step_q)
    );

    for (genvar p = 0; p < NTONES; p++) begin : g_path
        localparam int OTHER = 1 - p;
        logic [W-1:0] ld_val;
        logic         ld_en;
        logic         add_en;

        always_comb begin
            int tgt;
            if (p == 1)
                tgt = int'(words[OTHER]) + int'(step_q);
            else
                tgt = int'(words[OTHER]) - int'(step_q);
            ld_val = W'(sat_int(tgt, WMAX));
            ld_en  = ev.xfer && (ev.dest == tone_e'(p));
            add_en = ev.corr_ok && (tone_q == tone_e'(p));
        end

        fsk_tone_path #(.W(W), .CW(CW), .RESET_WORD(RESET_WORD)) path_i (
            .clk      (clk),
            .rst      (rst),
            .load_en  (ld_en),
            .load_val (ld_val),
            .add_en   (add_en),
            .corr     (corr),
            .word_q   (words[p])
        );
    end

    assign dac_lo   = words[0];
    assign dac_hi   = words[1];
    assign tone_sel = (tone_q == TONE_HI);

endmodule

// File: rtl/fsk_step_mod_chk.sv
`timescale 1ns/1ps
module fsk_step_mod_chk #(
    parameter int W          = 8,
    parameter int RESET_WORD = 128
) (
    input logic         clk,
    input logic         rst,
    input logic         sym_stb,
    input logic         data_bit,
    input logic         corr_vld,
    input logic [W-1:0] dac_lo,
    input logic [W-1:0] dac_hi,
    input logic         tone_sel
);

    logic sw;
    assign sw = sym_stb && (data_bit != tone_sel);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (dac_lo == W'(RESET_WORD) && dac_hi == W'(RESET_WORD) && !tone_sel));

    a_r2_sel_follows: assert property (@(posedge clk) disable iff (rst)
        sym_stb |=> (tone_sel == $past(data_bit)));

    a_r2_no_strobe_hold: assert property (@(posedge clk) disable iff (rst)
        !sym_stb |=> $stable(tone_sel));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!corr_vld && !sw) |=> ($stable(dac_lo) && $stable(dac_hi)));

    a_r3_inactive_hi: assert property (@(posedge clk) disable iff (rst)
        (!tone_sel && !sw) |=> $stable(dac_hi));

    a_r3_inactive_lo: assert property (@(posedge clk) disable iff (rst)
        (tone_sel && !sw) |=> $stable(dac_lo));

    a_r4_up_keeps_lo: assert property (@(posedge clk) disable iff (rst)
        (sw && data_bit) |=> $stable(dac_lo));

    a_r4_down_keeps_hi: assert property (@(posedge clk) disable iff (rst)
        (sw && !data_bit) |=> $stable(dac_hi));

endmodule

bind fsk_step_mod fsk_step_mod_chk #(.W(W), .RESET_WORD(RESET_WORD)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .sym_stb  (sym_stb),
    .data_bit (data_bit),
    .corr_vld (corr_vld),
    .dac_lo   (dac_lo),
    .dac_hi   (dac_hi),
    .tone_sel (tone_sel)
);

// File: tb/fsk_step_mod_tb_top.sv
`timescale 1ns/1ps
module fsk_step_mod_tb_top;

    localparam int W    = 8;
    localparam int CW   = 6;
    localparam int RW   = 128;
    localparam int WMAX = 255;
    localparam int CMAX = 31;
    localparam int CMIN = -32;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 sym_stb = 1'b0;
    logic                 data_bit = 1'b0;
    logic                 corr_vld = 1'b0;
    logic signed [CW-1:0] corr = '0;
    logic [W-1:0]         dac_lo;
    logic [W-1:0]         dac_hi;
    logic                 tone_sel;

    always #10 clk = ~clk;   // 50 MHz

    fsk_step_mod #(.W(W), .CW(CW), .RESET_WORD(RW)) dut_i (
        .clk(clk), .rst(rst), .sym_stb(sym_stb), .data_bit(data_bit),
        .corr_vld(corr_vld), .corr(corr),
        .dac_lo(dac_lo), .dac_hi(dac_hi), .tone_sel(tone_sel)
    );

    typedef struct {
        int    lo;
        int    hi;
        bit    sel;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // bench model of the requirements
    int m_lo = RW, m_hi = RW, m_step = 0;
    bit m_sel = 0;

    function automatic int clampw(int v);
        return (v < 0) ? 0 : ((v > WMAX) ? WMAX : v);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, pushes the expected next state
    task automatic cyc(input bit stb, input bit b, input bit cv, input int c,
                       input string tag);
        exp_t e;
        bit   sw;
        int   learned;
        @(negedge clk);
        sym_stb  = stb;
        data_bit = b;
        corr_vld = cv;
        corr     = CW'(c);
        sw = stb && (b != m_sel);
        if (sw) begin
            learned = m_hi - m_lo;
            if (b) m_hi = clampw(m_lo + m_step);
            else   m_lo = clampw(m_hi - m_step);
            m_step = learned;
            m_sel  = b;
        end else if (cv) begin
            if (m_sel) m_hi = clampw(m_hi + c);
            else       m_lo = clampw(m_lo + c);
        end
        e.lo = m_lo; e.hi = m_hi; e.sel = m_sel; e.tag = tag;
        q.push_back(e);
    endtask

    // imitate the loop: move the active word toward a target
    task automatic chase(input int tgt, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            int c;
            c = tgt - (m_sel ? m_hi : m_lo);
            if (c > CMAX) c = CMAX;
            if (c < CMIN) c = CMIN;
            cyc(1'b0, m_sel, 1'b1, c, tag);
        end
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                check(dac_lo == W'(e.lo), e.tag, "dac_lo", int'(dac_lo), e.lo);
                check(dac_hi == W'(e.hi), e.tag, "dac_hi", int'(dac_hi), e.hi);
                check(tone_sel == e.sel, e.tag, "tone_sel", int'(tone_sel), int'(e.sel));
            end
        end
    end

    // watchdog
    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(dac_lo == W'(RW), "R1", "dac_lo", int'(dac_lo), RW);
        check(dac_hi == W'(RW), "R1", "dac_hi", int'(dac_hi), RW);
        check(tone_sel == 1'b0, "R1", "tone_sel", int'(tone_sel), 0);

        // R3 corrections on the low tone only
        cyc(0, 0, 1, 5,  "R3");
        cyc(0, 0, 1, -3, "R3");
        cyc(0, 0, 0, 20, "R3");
        // R2 bit change without strobe ignored
        cyc(0, 1, 1, 4,  "R2");
        // R6 strobe with same bit: no switch
        cyc(1, 0, 1, 2,  "R6");
        // R5 first switch uses step 0, R8 correction dropped
        cyc(1, 1, 1, 17, "R5_R8");
        cyc(0, 1, 1, 20, "R3");
        cyc(0, 1, 1, 20, "R3");
        cyc(1, 1, 0, 0,  "R6");
        // R4 down switch
        cyc(1, 0, 1, -9, "R4_R8");
        cyc(0, 0, 1, -15, "R3");
        cyc(1, 1, 0, 0,  "R4");
        cyc(1, 0, 0, 0,  "R4");

        // R5 convergence: loop settles tones at 100 and 140
        cyc(0, 0, 0, 0, "R5");
        for (int k = 0; k < 4; k++) begin
            chase(100, 12, "R5");
            cyc(1, 1, 0, 0, "R5");
            chase(140, 12, "R5");
            cyc(1, 0, 0, 0, "R5");
        end
        drain();
        check(dac_lo == 8'd100, "R5", "converged dac_lo", int'(dac_lo), 100);
        cyc(1, 1, 0, 0, "R5");
        drain();
        check(dac_hi == 8'd140, "R5", "converged dac_hi", int'(dac_hi), 140);

        // R7 saturation, fresh reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_lo = RW; m_hi = RW; m_step = 0; m_sel = 0;
        sym_stb = 0; corr_vld = 0;
        cyc(1, 1, 0, 0, "R7");                       // hi=128, step 0
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, -32, "R7");   // hi -> 0
        cyc(1, 0, 0, 0, "R7");                       // lo=0, step=-128
        for (int i = 0; i < 10; i++) cyc(0, 0, 1, 31, "R7");   // lo -> 255
        cyc(1, 1, 0, 0, "R7");                       // hi=127, step=-255
        cyc(1, 0, 0, 0, "R7");                       // lo clamps at 255
        drain();
        check(dac_lo == 8'd255, "R7", "load clamp dac_lo", int'(dac_lo), 255);
        check(dac_hi == 8'd127, "R7", "dac_hi", int'(dac_hi), 127);
        finish_run();
    end

endmodule